// File: doc/BRIEF.md
# Per-Channel Audio Idle Mute Detector

This block sits on a stereo sample stream and mutes each channel on its own once that channel's data has stopped moving. Every accepted sample is sorted into one of three kinds: all bits clear, all bits set, or anything else. A channel keeps a run counter of back-to-back samples of the same constant kind. When the run reaches the threshold, the channel's mute flag rises. The first sample that breaks the run drops the flag again. A break is either a changing sample or a flip between the all-clear and all-set kinds.

The two channels run fully apart. A combined mute-control output is active whenever either channel is muted, and a parameter sets its polarity. An enable input gates the whole function. While the enable is low, both counters are held at zero and both flags are held low.

Top module: `audio_idle_mute`

## Requirements
- R1: After reset both mute flags are low and the mute-control pin is inactive (low when PIN_ACTIVE_HIGH is 1).
- R2: With the enable high, a channel's flag rises on the clock edge that accepts its RUN_LEN-th consecutive static sample (default 8192). After RUN_LEN-1 such samples it is still low. Static means every bit is 0 or every bit is 1.
- R3: A non-static sample accepted on a channel clears that channel's flag on the same clock edge.
- R4: The left and right channels keep separate counters and flags. Data on one channel never changes the other channel's flag.
- R5: A change from all-zero samples to all-one samples, or the reverse, restarts the run at one and clears the flag. A further RUN_LEN-1 samples of the new kind are then needed to mute again.
- R6: The counters and flags change only on clocks where the sample-valid strobe is high. Idle clocks neither advance a partial run nor change a flag.
- R7: When the enable is low at a clock edge, both flags are low and both counters are zero after that edge. Once the enable returns, a full run of RUN_LEN samples is needed to mute.
- R8: Once a run reaches RUN_LEN, further matching samples keep the flag high. The counter saturates and does not wrap.
- R9: The mute-control pin is active exactly when at least one channel flag is high.
- R10: Samples accepted while the enable is low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; one stereo sample accepted per high cycle |
| smp_left | input | SAMPLE_W | Left channel sample word |
| smp_right | input | SAMPLE_W | Right channel sample word |
| auto_mute_en | input | 1 | Enables idle detection; low clears both channels |
| mute_left | output | 1 | Left channel muted flag |
| mute_right | output | 1 | Right channel muted flag |
| mute_pin | output | 1 | Combined mute-control output, polarity set by PIN_ACTIVE_HIGH |

## Verification
Two events can land on the same edge. One channel can reach its threshold while the other channel breaks its run. Separately, the enable can drop on an edge where a sample is also being accepted. The bench provokes the first case by completing a run on the right channel while the left channel carries changing data, and then checks that each flag and the combined pin follow only their own channel. It provokes the second case by dropping the enable while static samples keep arriving, and judges that the clear wins. It then requires a full fresh run after the enable comes back.

// File: rtl/idle_mute_pkg.sv
package idle_mute_pkg;
  typedef enum logic [1:0] {
    KIND_MIXED = 2'd0,
    KIND_ZERO  = 2'd1,
    KIND_ONES  = 2'd2
  } run_kind_t;
endpackage

// File: rtl/idle_mute_chan.sv
module idle_mute_chan
  import idle_mute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192,
  localparam int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                muted_o,
  output logic [CNT_W-1:0]    run_cnt_o,
  output logic                brk_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  function automatic run_kind_t sample_kind(input logic [SAMPLE_W-1:0] s);
    if (s == '0)      return KIND_ZERO;
    else if (s == '1) return KIND_ONES;
    else              return KIND_MIXED;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c >= LIMIT) ? LIMIT : c + CNT_W'(1);
  endfunction

  run_kind_t        kind_now, last_kind;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             muted_q;

  assign kind_now = sample_kind(sample_i);
  assign brk_o    = en_i && valid_i &&
                    (kind_now == KIND_MIXED || kind_now != last_kind);

  always_comb begin
    cnt_nxt = cnt_q;
    if (valid_i) begin
      if (kind_now == KIND_MIXED)     cnt_nxt = '0;
      else if (kind_now != last_kind) cnt_nxt = CNT_W'(1);
      else                            cnt_nxt = bump(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      last_kind <= KIND_MIXED;
      muted_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      last_kind <= KIND_MIXED;
      muted_q   <= 1'b0;
    end else if (valid_i) begin
      cnt_q     <= cnt_nxt;
      last_kind <= kind_now;
      muted_q   <= (cnt_nxt == LIMIT);
    end
  end

  assign muted_o   = muted_q;
  assign run_cnt_o = cnt_q;
endmodule

// File: rtl/idle_mute_pin.sv
module idle_mute_pin #(
  parameter int N_CH        = 2,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic [N_CH-1:0] muted_i,
  output logic            pin_o
);
  logic any_muted;
  assign any_muted = |muted_i;

  generate
    if (ACTIVE_HIGH) begin : g_high
      assign pin_o = any_muted;
    end else begin : g_low
      assign pin_o = ~any_muted;
    end
  endgenerate
endmodule

// File: rtl/audio_idle_mute.sv
module audio_idle_mute #(
  parameter int SAMPLE_W        = 24,
  parameter int RUN_LEN         = 8192,
  parameter bit PIN_ACTIVE_HIGH = 1'b1,
  localparam int N_CH           = 2,
  localparam int CNT_W          = $clog2(RUN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                auto_mute_en,
  output logic                mute_left,
  output logic                mute_right,
  output logic                mute_pin
);
  logic [SAMPLE_W-1:0] ch_sample [N_CH];
  logic [CNT_W-1:0]    run_cnt   [N_CH];
  logic [N_CH-1:0]     ch_muted;
  logic [N_CH-1:0]     ch_brk;

  assign ch_sample[0] = smp_left;
  assign ch_sample[1] = smp_right;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      idle_mute_chan #(
        .SAMPLE_W(SAMPLE_W),
        .RUN_LEN (RUN_LEN)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (auto_mute_en),
        .valid_i  (smp_valid),
        .sample_i (ch_sample[c]),
        .muted_o  (ch_muted[c]),
        .run_cnt_o(run_cnt[c]),
        .brk_o    (ch_brk[c])
      );
    end
  endgenerate

  idle_mute_pin #(
    .N_CH       (N_CH),
    .ACTIVE_HIGH(PIN_ACTIVE_HIGH)
  ) u_pin (
    .muted_i(ch_muted),
    .pin_o  (mute_pin)
  );

  assign mute_left  = ch_muted[0];
  assign mute_right = ch_muted[1];
endmodule

// File: rtl/audio_idle_mute_chk.sv
module audio_idle_mute_chk #(
  parameter int RUN_LEN     = 8192,
  parameter bit ACTIVE_HIGH = 1'b1,
  localparam int CNT_W      = $clog2(RUN_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             valid,
  input logic             mute_left,
  input logic             mute_right,
  input logic             mute_pin,
  input logic [CNT_W-1:0] cnt_l,
  input logic [CNT_W-1:0] cnt_r,
  input logic [1:0]       brk
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_l <= LIMIT) && (cnt_r <= LIMIT));

  p_entry_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_left) |-> (cnt_l == LIMIT));

  p_break_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk[0] |=> !mute_left);

  p_break_releases_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk[1] |=> !mute_right);

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !valid) |=> ($stable(cnt_l) && $stable(cnt_r) && $stable(mute_left) && $stable(mute_right)));

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!mute_left && !mute_right && cnt_l == '0 && cnt_r == '0));

  p_pin_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mute_pin == (ACTIVE_HIGH ? (mute_left || mute_right) : !(mute_left || mute_right)));
endmodule

bind audio_idle_mute audio_idle_mute_chk #(
  .RUN_LEN    (RUN_LEN),
  .ACTIVE_HIGH(PIN_ACTIVE_HIGH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (auto_mute_en),
  .valid     (smp_valid),
  .mute_left (mute_left),
  .mute_right(mute_right),
  .mute_pin  (mute_pin),
  .cnt_l     (run_cnt[0]),
  .cnt_r     (run_cnt[1]),
  .brk       (ch_brk)
);

// File: tb/audio_idle_mute_tb.sv
module audio_idle_mute_tb;
  localparam int W   = 24;
  localparam int RUN = 8192;
  localparam logic [W-1:0] Z = '0;
  localparam logic [W-1:0] O = '1;
  localparam logic [W-1:0] MIX = 24'h5A3C71;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic en = 1'b1;
  logic [W-1:0] sl = MIX, sr = MIX;
  logic ml, mr, pin;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audio_idle_mute #(.SAMPLE_W(W), .RUN_LEN(RUN), .PIN_ACTIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(valid), .smp_left(sl), .smp_right(sr),
    .auto_mute_en(en), .mute_left(ml), .mute_right(mr), .mute_pin(pin));

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // feed n samples, one per cycle, then idle; results are sampled at a negedge
  task automatic feed(input logic [W-1:0] l, input logic [W-1:0] r, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); valid = 1'b1; sl = l; sr = r;
    end
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 left", ml, 1'b0); chk("R1 right", mr, 1'b0); chk("R1 pin", pin, 1'b0);
  endtask

  task automatic t_entry_release;
    feed(Z, MIX, RUN - 1);
    chk("R2 below threshold", ml, 1'b0);
    feed(Z, MIX, 1);
    chk("R2 at threshold", ml, 1'b1);
    chk("R4 right unaffected", mr, 1'b0);
    chk("R9 pin on", pin, 1'b1);
    feed(24'h000001, MIX, 1);
    chk("R3 release", ml, 1'b0);
    chk("R9 pin off", pin, 1'b0);
  endtask

  task automatic t_switch_saturate;
    feed(O, MIX, RUN);
    chk("R2 all-ones run", ml, 1'b1);
    feed(Z, MIX, 1);
    chk("R5 flip clears", ml, 1'b0);
    feed(Z, MIX, RUN - 2);
    chk("R5 restart count one short", ml, 1'b0);
    feed(Z, MIX, 1);
    chk("R5 restart count reached", ml, 1'b1);
    feed(Z, MIX, RUN + 100);
    chk("R8 saturate holds", ml, 1'b1);
    idle(50);
    chk("R6 idle keeps flag", ml, 1'b1);
  endtask

  task automatic t_idle_partial;
    feed(MIX, MIX, 1);
    feed(Z, MIX, 4000);
    idle(500);
    feed(Z, MIX, RUN - 4000 - 1);
    chk("R6 idle did not advance", ml, 1'b0);
    feed(Z, MIX, 1);
    chk("R6 partial run resumes", ml, 1'b1);
    feed(MIX, MIX, 1);
  endtask

  task automatic t_independent;
    feed(24'h000010, O, RUN - 1);
    feed(24'h000020, O, 1);
    chk("R4 right muted", mr, 1'b1);
    chk("R4 left changing stays unmuted", ml, 1'b0);
    chk("R9 pin from right", pin, 1'b1);
  endtask

  task automatic t_enable;
    @(negedge clk); en = 1'b0; valid = 1'b1; sl = Z; sr = O;
    @(negedge clk);
    chk("R7 right cleared", mr, 1'b0);
    chk("R7 pin cleared", pin, 1'b0);
    valid = 1'b0;
    feed(Z, O, RUN + 10);
    chk("R10 left ignored", ml, 1'b0);
    chk("R10 right ignored", mr, 1'b0);
    @(negedge clk); en = 1'b1;
    feed(Z, O, RUN - 1);
    chk("R7 fresh run needed", mr, 1'b0);
    feed(Z, O, 1);
    chk("R7 mutes after full run", mr, 1'b1);
    chk("R7 left too", ml, 1'b1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_entry_release();
    t_switch_saturate();
    t_idle_partial();
    t_independent();
    t_enable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule